// File: doc/BRIEF.md
# Register Exchange Execute Unit

This unit decodes and executes register-to-register exchange instructions for a core whose registers are 64 bits wide but whose default operand size is 32 bits. Each instruction is one opcode byte, sometimes followed by an operand-selector byte. The unit accepts it through a valid/ready handshake and swaps the two named registers in its eight-entry register file. When the operands are 32 bits wide, both results are zero-extended to 64 bits. A width input selects full 64-bit swaps instead.

Opcode 0x90 gets special treatment. Read literally, it would be a 32-bit exchange of the accumulator with itself, which would clear the accumulator's upper half. Here it is a pure no-operation instead. It finishes in one cycle, writes nothing, never waits on an outstanding accumulator write, and never marks the accumulator as having a pending result. The two-byte form 0x87 0xC0 keeps the literal meaning and clears the upper half.

Other logic in the core can write the register file through a load port. Its contents can be observed through a combinational read port. An input tells the unit that an external accumulator write is still outstanding. An output shows the unit's own pending accumulator write.

Top module: `xchg_unit`

## Requirements
- R1: After synchronous reset, all eight registers read zero, `done` and `acc_pend` are low, and `in_ready` is high while `ext_acc_busy` is low.
- R2: Opcode 0x90 leaves every register unchanged, including bits 63:32 of register 0, whatever the value of `in_wide`. `done` pulses in the first cycle after acceptance.
- R3: Opcodes 0x91 through 0x97 swap register 0 with the register whose index is the opcode's bits 2:0.
- R4: Opcode 0x87 followed by a selector byte whose bits 7:6 are 11 swaps the register indexed by bits 5:3 with the register indexed by bits 2:0.
- R5: With `in_wide` low, every written register receives the 32-bit value zero-extended. For example, 0x87 0xC0 keeps bits 31:0 of register 0 and clears bits 63:32.
- R6: With `in_wide` high, an exchange swaps the full 64-bit values, so 0x87 0xC0 leaves register 0 unchanged.
- R7: For an exchange, `done` is high in exactly the third cycle after acceptance and `in_ready` stays low until then. The new register values are visible on the read port in the cycle after `done`.
- R8: Opcode 0x87 whose selector bits 7:6 are not 11, and any opcode other than 0x87 and 0x90 through 0x97, raise `bad_op` together with `done` in the first cycle after acceptance. Such an instruction changes no register.
- R9: While `ext_acc_busy` is high, an exchange that names register 0 is held off (`in_ready` low). Opcode 0x90 and exchanges that do not name register 0 are still accepted.
- R10: `acc_pend` is high from the cycle after an exchange naming register 0 is accepted, through its `done` cycle. It is never set by 0x90, by rejected opcodes, or by exchanges that do not name register 0.
- R11: A `ld_en` cycle writes `ld_data` into register `ld_idx` at the clock edge. `rd_data` shows register `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept the instruction |
| in_opcode | input | 8 | Opcode byte |
| in_modrm | input | 8 | Operand-selector byte (used with 0x87) |
| in_wide | input | 1 | 1 = 64-bit operands, 0 = 32-bit |
| ext_acc_busy | input | 1 | External accumulator write still outstanding |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 3 | Register load index |
| ld_data | input | 64 | Register load value |
| rd_idx | input | 3 | Read port index |
| rd_data | output | 64 | Read port value |
| done | output | 1 | Last cycle of an instruction |
| bad_op | output | 1 | Instruction rejected (with `done`) |
| acc_pend | output | 1 | Unit holds a pending write to register 0 |

## Verification
A wrong cycle count in the sequencer shows up on `done` within one to three cycles of acceptance, and the bench measures that distance exactly. A decode or zero-extension fault lands in the register file, where it becomes visible on the read port the cycle after `done`. The bench sweeps all eight registers there against its own model. A faulty pending-accumulator bit shows on `acc_pend` in the first busy cycle. A fault in the stall condition appears on `in_ready` in the same cycle the instruction is presented.

// File: rtl/xchg_pkg.sv
`timescale 1ns/1ps
package xchg_pkg;
    localparam int NREG = 8;
    localparam int IDXW = $clog2(NREG);
    localparam int DW   = 64;
    localparam int HW   = DW / 2;

    localparam logic [7:0] OPC_PAUSE   = 8'h90;
    localparam logic [7:0] OPC_SWAP_RM = 8'h87;
    localparam logic [4:0] OPC_ACC_HI  = 5'b10010;
    localparam logic [1:0] MOD_REGREG  = 2'b11;

    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_SWAP = 2'd1,
        OP_BAD  = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic [IDXW-1:0]   ra;
        logic [IDXW-1:0]   rb;
        logic              wide;
        logic              uses_acc;
    } xdec_t;

    function automatic xdec_t xdecode(input logic [7:0] opc,
                                      input logic [7:0] sel,
                                      input logic       wide);
        xdec_t d;
        d.kind     = OP_BAD;
        d.ra       = '0;
        d.rb       = '0;
        d.wide     = wide;
        d.uses_acc = 1'b0;
        if (opc == OPC_PAUSE) begin
            d.kind = OP_NOP;
        end else if (opc[7:3] == OPC_ACC_HI) begin
            d.kind = OP_SWAP;
            d.rb   = opc[2:0];
        end else if (opc == OPC_SWAP_RM && sel[7:6] == MOD_REGREG) begin
            d.kind = OP_SWAP;
            d.ra   = sel[5:3];
            d.rb   = sel[2:0];
        end
        d.uses_acc = (d.kind == OP_SWAP) && (d.ra == '0 || d.rb == '0);
        return d;
    endfunction

    function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input logic wide);
        return wide ? v : {{HW{1'b0}}, v[HW-1:0]};
    endfunction
endpackage

// File: rtl/xchg_regfile.sv
`timescale 1ns/1ps
module xchg_regfile
    import xchg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [DW-1:0]   ld_data,
    input  logic            sw_en,
    input  logic [IDXW-1:0] sw_a,
    input  logic [IDXW-1:0] sw_b,
    input  logic            sw_wide,
    input  logic [IDXW-1:0] rd_idx,
    output logic [DW-1:0]   rd_data
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (sw_en && IDXW'(i) == sw_a)
                    regs[i] <= fit(regs[sw_b], sw_wide);
                else if (sw_en && IDXW'(i) == sw_b)
                    regs[i] <= fit(regs[sw_a], sw_wide);
                else if (ld_en && IDXW'(i) == ld_idx)
                    regs[i] <= ld_data;
            end
        end
    end

    assign rd_data = regs[rd_idx];

    // check support: remember the last narrow swap
    logic            nchk_q;
    logic [IDXW-1:0] na_q, nb_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            nchk_q <= 1'b0;
            na_q   <= '0;
            nb_q   <= '0;
        end else begin
            nchk_q <= sw_en && !sw_wide;
            na_q   <= sw_a;
            nb_q   <= sw_b;
        end
    end

    AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (rst)
        nchk_q |-> (regs[na_q][DW-1:HW] == '0 && regs[nb_q][DW-1:HW] == '0)); // R5
endmodule

// File: rtl/xchg_seq.sv
`timescale 1ns/1ps
module xchg_seq
    import xchg_pkg::*;
#(
    parameter int XCHG_CYCLES = 3,
    parameter int NOP_CYCLES  = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  xdec_t dec,
    input  logic  ext_acc_busy,
    output logic  in_ready,
    output logic  idle,
    output logic  done,
    output logic  bad_op,
    output logic  commit,
    output xdec_t cur,
    output logic  acc_pend
);
    localparam int MAXC = (XCHG_CYCLES > NOP_CYCLES) ? XCHG_CYCLES : NOP_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic          busy;
    logic [CW-1:0] cnt;
    logic          accept;

    assign idle     = !busy;
    assign in_ready = !busy && !(ext_acc_busy && dec.uses_acc);
    assign accept   = in_valid && in_ready;
    assign done     = busy && cnt == CW'(1);
    assign bad_op   = done && cur.kind == OP_BAD;
    assign commit   = done && cur.kind == OP_SWAP;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy         <= 1'b0;
            cnt          <= '0;
            acc_pend     <= 1'b0;
            cur.kind     <= OP_NOP;
            cur.ra       <= '0;
            cur.rb       <= '0;
            cur.wide     <= 1'b0;
            cur.uses_acc <= 1'b0;
        end else if (accept) begin
            busy     <= 1'b1;
            cnt      <= (dec.kind == OP_SWAP) ? CW'(XCHG_CYCLES) : CW'(NOP_CYCLES);
            cur      <= dec;
            acc_pend <= dec.uses_acc;
        end else if (busy) begin
            if (cnt == CW'(1)) begin
                busy     <= 1'b0;
                acc_pend <= 1'b0;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    // independent age counter for the latency check
    logic [7:0] age;
    always_ff @(posedge clk) begin
        if (rst)         age <= '0;
        else if (accept) age <= 8'd1;
        else if (busy)   age <= age + 8'd1;
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(age) == ((cur.kind == OP_SWAP) ? XCHG_CYCLES : NOP_CYCLES))); // R7
    AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && cur.uses_acc) |-> acc_pend); // R10
    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
        done |=> !acc_pend); // R10
endmodule

// File: rtl/xchg_unit.sv
`timescale 1ns/1ps
module xchg_unit
    import xchg_pkg::*;
#(
    parameter int XCHG_CYCLES = 3,
    parameter int NOP_CYCLES  = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [7:0]      in_opcode,
    input  logic [7:0]      in_modrm,
    input  logic            in_wide,
    input  logic            ext_acc_busy,
    input  logic            ld_en,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [DW-1:0]   ld_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic            done,
    output logic            bad_op,
    output logic            acc_pend
);
    xdec_t dec, cur;
    logic  commit, idle;

    assign dec = xdecode(in_opcode, in_modrm, in_wide);

    xchg_seq #(
        .XCHG_CYCLES(XCHG_CYCLES),
        .NOP_CYCLES (NOP_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .dec         (dec),
        .ext_acc_busy(ext_acc_busy),
        .in_ready    (in_ready),
        .idle        (idle),
        .done        (done),
        .bad_op      (bad_op),
        .commit      (commit),
        .cur         (cur),
        .acc_pend    (acc_pend)
    );

    xchg_regfile u_rf (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_idx (ld_idx),
        .ld_data(ld_data),
        .sw_en  (commit),
        .sw_a   (cur.ra),
        .sw_b   (cur.rb),
        .sw_wide(cur.wide),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

    AST_NOP_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (idle && in_valid && in_opcode == OPC_PAUSE) |-> in_ready); // R9
    AST_NOP_NO_PRODUCER: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_opcode == OPC_PAUSE) |=> !acc_pend); // R10
    AST_NOP_SHORT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_opcode == OPC_PAUSE) |=> (done && !bad_op)); // R2
endmodule

// File: tb/sim_xchg_unit.sv
`timescale 1ns/1ps
module sim_xchg_unit;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, in_valid, in_ready, in_wide, ext_acc_busy, ld_en;
    logic [7:0]  in_opcode, in_modrm;
    logic [2:0]  ld_idx, rd_idx;
    logic [63:0] ld_data, rd_data;
    logic        done, bad_op, acc_pend;

    int total = 0;
    int bad   = 0;
    logic [63:0] m [8];

    xchg_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_modrm(in_modrm), .in_wide(in_wide),
        .ext_acc_busy(ext_acc_busy), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .done(done), .bad_op(bad_op), .acc_pend(acc_pend)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // 0 = no-op, 1 = exchange, 2 = rejected
    function automatic int cls(input logic [7:0] op, input logic [7:0] mr);
        if (op == 8'h90) return 0;
        if (op >= 8'h91 && op <= 8'h97) return 1;
        if (op == 8'h87 && mr[7:6] == 2'b11) return 1;
        return 2;
    endfunction

    function automatic logic [63:0] zx(input logic [63:0] v, input bit w);
        return w ? v : {32'h0, v[31:0]};
    endfunction

    task automatic check_regs(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #0.25;
            chk(rd_data === m[i], req, $sformatf("reg%0d", i), rd_data, m[i]);
        end
    endtask

    task automatic load(input int i, input logic [63:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 3'(i); ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
        m[i] = v;
    endtask

    task automatic load_all();
        for (int i = 0; i < 8; i++)
            load(i, {$urandom(), $urandom()} | 64'h8000_0001_0000_0000);
    endtask

    task automatic run(input logic [7:0] op, input logic [7:0] mr,
                       input bit w, input bit ext, input string req);
        int k = cls(op, mr);
        logic [2:0] a, b;
        bit uacc;
        int cyc, lat;
        logic [63:0] va, vb;
        if (op == 8'h87) begin a = mr[5:3]; b = mr[2:0]; end
        else begin a = 3'd0; b = op[2:0]; end
        uacc = (k == 1) && (a == 3'd0 || b == 3'd0);
        lat  = (k == 1) ? 3 : 1;
        @(negedge clk);
        in_valid = 1'b1; in_opcode = op; in_modrm = mr; in_wide = w;
        ext_acc_busy = ext;
        #0.25;
        chk(in_ready === !(ext && uacc), "R9", "ready on presentation",
            64'(in_ready), 64'(!(ext && uacc)));
        while (!in_ready) begin @(negedge clk); #0.25; end
        @(negedge clk);
        in_valid = 1'b0; ext_acc_busy = 1'b0;
        chk(acc_pend === uacc, "R10", "acc_pend first cycle", 64'(acc_pend), 64'(uacc));
        cyc = 1;
        while (done !== 1'b1 && cyc < 10) begin @(negedge clk); cyc++; end
        chk(cyc == lat, (k == 1) ? "R7" : (k == 0 ? "R2" : "R8"), "done latency",
            64'(cyc), 64'(lat));
        chk(bad_op === (k == 2), "R8", "bad_op", 64'(bad_op), 64'(k == 2));
        if (k == 1) begin
            va = m[a]; vb = m[b];
            m[a] = zx(vb, w);
            m[b] = zx(va, w);
        end
        @(negedge clk);
        chk(acc_pend === 1'b0, "R10", "acc_pend after done", 64'(acc_pend), 64'h0);
        check_regs(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; in_opcode = '0; in_modrm = '0; in_wide = 1'b0;
        ext_acc_busy = 1'b0; ld_en = 1'b0; ld_idx = '0; ld_data = '0; rd_idx = '0;
        for (int i = 0; i < 8; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(in_ready === 1'b1, "R1", "in_ready", 64'(in_ready), 64'h1);
        chk(done === 1'b0, "R1", "done", 64'(done), 64'h0);
        chk(acc_pend === 1'b0, "R1", "acc_pend", 64'(acc_pend), 64'h0);
        check_regs("R1");

        // R11 load and read back
        load_all();
        @(negedge clk);
        check_regs("R11");

        // R2 no-op keeps upper accumulator half, both widths
        run(8'h90, 8'h00, 1'b0, 1'b0, "R2");
        run(8'h90, 8'hC0, 1'b1, 1'b0, "R2");
        // R3 accumulator exchanges
        run(8'h91, 8'h00, 1'b0, 1'b0, "R3");
        run(8'h97, 8'h00, 1'b0, 1'b0, "R3");
        load_all();
        // R6 full width
        run(8'h93, 8'h00, 1'b1, 1'b0, "R6");
        // R5 two-byte self exchange clears upper half; R6 wide keeps it
        run(8'h87, 8'hC0, 1'b1, 1'b0, "R6");
        run(8'h87, 8'hC0, 1'b0, 1'b0, "R5");
        load_all();
        // R4 general register form
        run(8'h87, 8'hD9, 1'b0, 1'b0, "R4");
        run(8'h87, 8'hFE, 1'b1, 1'b0, "R4");
        // R8 rejected forms
        run(8'h87, 8'h48, 1'b0, 1'b0, "R8");
        run(8'h86, 8'hC1, 1'b0, 1'b0, "R8");

        // R9 stall: accumulator exchange held while external write outstanding
        @(negedge clk);
        in_valid = 1'b1; in_opcode = 8'h92; in_modrm = 8'h00; in_wide = 1'b0;
        ext_acc_busy = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #0.25;
            chk(in_ready === 1'b0, "R9", "held off", 64'(in_ready), 64'h0);
            chk(done === 1'b0, "R9", "no done while held", 64'(done), 64'h0);
            @(negedge clk);
        end
        in_valid = 1'b0; ext_acc_busy = 1'b0;
        check_regs("R9");
        // no-op and non-accumulator exchange still go through
        run(8'h90, 8'h00, 1'b0, 1'b1, "R9");
        run(8'h87, 8'hD3, 1'b0, 1'b1, "R9");

        // random mix
        for (int it = 0; it < 160; it++) begin
            logic [7:0] op, mr;
            int r;
            bit w, ext;
            if (it % 12 == 0) load_all();
            r = $urandom_range(0, 11);
            if (r <= 7)       op = 8'h90 + 8'(r);
            else if (r <= 9)  op = 8'h87;
            else if (r == 10) op = 8'($urandom());
            else              op = 8'h90;
            mr = 8'($urandom());
            if ($urandom_range(0, 3) != 0) mr[7:6] = 2'b11;
            w = 1'($urandom());
            ext = ($urandom_range(0, 3) == 0);
            if (cls(op, mr) == 1 &&
                ((op == 8'h87) ? (mr[5:3] == 3'd0 || mr[2:0] == 3'd0) : 1'b1))
                ext = 1'b0;
            run(op, mr, w, ext, "R3");
        end
        summary();
    end
endmodule